// File: doc/BRIEF.md
# Request/Reply Input Queue with Spill and Loopback

This block is the receive buffer of a node on a request/response network. Every incoming transaction is taken in the cycle it arrives, even when the node cannot issue any traffic of its own. This matters because a request may have to produce a reply. Requests and replies go into two separate FIFOs. Each FIFO is sized for the worst case of its own class, so a full request FIFO can never block a reply.

When the request FIFO is full, the block can answer in one of two ways, chosen by a configuration bit. In refuse mode the new request is rejected with a one-cycle NACK in the same cycle. In spill mode the block first waits for a programmable number of full cycles. After that it sends all later requests into a larger spill FIFO. A loopback path then moves those requests back into the request FIFO, oldest first, whenever there is room. Loopback transfers give way to network arrivals, but a transfer is forced after a fixed number of cycles spent waiting.

Occupancy of all three FIFOs and a spill-active flag are brought out so that the node can watch the queue pressure.

Top module: `reqrep_inq`

## Requirements
- R1: A reply arrival (net_valid_i=1, net_is_req_i=0) is always written to the reply FIFO and is never NACKed. Replies leave the reply FIFO in arrival order.
- R2: Requests and replies are held in separate FIFOs. Requests leave in acceptance order on req_data_o, and replies leave in acceptance order on rsp_data_o. Each FIFO is popped by its own pop input.
- R3: The request FIFO holds K_OUT*(NODES-1) entries. The reply FIFO holds K_OUT entries. The spill FIFO holds SPILL_DEPTH entries.
- R4: A request that is neither written to the request FIFO nor written to the spill FIFO raises nack_o in the same cycle and leaves every FIFO unchanged. This happens in two cases: spill inactive with the request FIFO full, or spill active with the spill FIFO full.
- R5: spill_active_o rises after the clock edge that ends the cycle in which three conditions hold: spill_mode_i=1, the request FIFO is full, and it has already been full for spill_thresh_i consecutive earlier cycles. It therefore rises after spill_thresh_i+1 full cycles.
- R6: While spill_active_o=1, every request goes to the spill FIFO. Requests are never written straight to the request FIFO in this state, which keeps arrival order. The spill FIFO is non-empty only while spill_active_o=1.
- R7: A loopback transfer moves the oldest spill entry into the request FIFO when the spill FIFO is non-empty and the request FIFO is not full. It happens in a cycle with no network arrival, or after LOOP_PERIOD-1 consecutive eligible cycles were lost to arrivals.
- R8: req_count_o, rsp_count_o and spill_count_o give the current number of entries in each FIFO.
- R9: spill_active_o falls when one of two things happens. Either a loopback transfer empties the spill FIFO in a cycle with no spill write, or spill_mode_i=0 while the spill FIFO is empty and not being written.
- R10: After reset, all FIFOs are empty, spill_active_o=0 and nack_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spill_mode_i | input | 1 | 1 = spill on overflow, 0 = refuse with NACK |
| spill_thresh_i | input | THRESH_W | Number of full cycles tolerated before spilling starts |
| net_valid_i | input | 1 | A transaction arrives this cycle |
| net_is_req_i | input | 1 | 1 = request, 0 = reply |
| net_data_i | input | DATA_W | Transaction payload |
| nack_o | output | 1 | The current request is refused |
| req_valid_o | output | 1 | The request FIFO is non-empty |
| req_data_o | output | DATA_W | Head of the request FIFO |
| req_pop_i | input | 1 | Remove the head of the request FIFO |
| rsp_valid_o | output | 1 | The reply FIFO is non-empty |
| rsp_data_o | output | DATA_W | Head of the reply FIFO |
| rsp_pop_i | input | 1 | Remove the head of the reply FIFO |
| req_count_o | output | $clog2(K_OUT*(NODES-1)+1) | Request FIFO occupancy |
| rsp_count_o | output | $clog2(K_OUT+1) | Reply FIFO occupancy |
| spill_count_o | output | $clog2(SPILL_DEPTH+1) | Spill FIFO occupancy |
| spill_active_o | output | 1 | Spill mode is engaged |

## Verification
The checks assume two things about the environment. First, a reply never arrives while the reply FIFO is full, because its slot was reserved when the matching request was issued. Second, neither pop input is raised while its FIFO is empty. The stimulus keeps within these limits by tracking a model occupancy for each FIFO. It drops a reply arrival when the reply model is full and masks a pop when the matching model queue is empty. Requests, by contrast, are sent freely, including long back-to-back bursts, so that refusal, spill entry and forced loopback all occur.

// File: rtl/reqrep_pkg.sv
package reqrep_pkg;
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_QUEUE = 2'd1,
    RT_SPILL = 2'd2,
    RT_NACK  = 2'd3
  } req_route_e;
endpackage

// File: rtl/reqrep_fifo.sv
module reqrep_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign do_pop  = pop_i && (count_q != '0);
  assign do_push = push_i && (count_q != CW'(DEPTH));

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/reqrep_spill_ctrl.sv
module reqrep_spill_ctrl
  import reqrep_pkg::*;
#(
  parameter int THRESH_W    = 4,
  parameter int LOOP_PERIOD = 4,
  localparam int SW         = $clog2(LOOP_PERIOD + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spill_mode_i,
  input  logic [THRESH_W-1:0] thresh_i,
  input  logic                net_valid_i,
  input  logic                net_is_req_i,
  input  logic                req_full_i,
  input  logic                spill_empty_i,
  input  logic                spill_full_i,
  input  logic                spill_last_i,
  output req_route_e          route_o,
  output logic                relaunch_o,
  output logic                active_o
);
  logic                active_q;
  logic [THRESH_W-1:0] full_cnt_q;
  logic [SW-1:0]       starve_q;
  logic                eligible, forced, spill_push, full_watch;

  always_comb begin
    route_o = RT_NONE;
    if (net_valid_i && net_is_req_i) begin
      if (active_q) route_o = spill_full_i ? RT_NACK : RT_SPILL;
      else          route_o = req_full_i   ? RT_NACK : RT_QUEUE;
    end
  end

  assign spill_push = (route_o == RT_SPILL);
  assign eligible   = !spill_empty_i && !req_full_i;
  assign forced     = (starve_q == SW'(LOOP_PERIOD - 1));
  // loopback yields to any arrival unless it has waited long enough
  assign relaunch_o = eligible && (!net_valid_i || forced);
  assign full_watch = !active_q && spill_mode_i && req_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      full_cnt_q <= '0;
      starve_q   <= '0;
    end else begin
      if (active_q) begin
        if ((relaunch_o && spill_last_i && !spill_push) ||
            (!spill_mode_i && spill_empty_i && !spill_push))
          active_q <= 1'b0;
      end else if (full_watch && full_cnt_q == thresh_i) begin
        active_q <= 1'b1;
      end

      if (full_watch && full_cnt_q != thresh_i) full_cnt_q <= full_cnt_q + 1'b1;
      else                                      full_cnt_q <= '0;

      if (relaunch_o)                  starve_q <= '0;
      else if (eligible && net_valid_i) starve_q <= starve_q + 1'b1;
      else                             starve_q <= '0;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/reqrep_inq.sv
module reqrep_inq
  import reqrep_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int K_OUT       = 2,
  parameter int NODES       = 3,
  parameter int SPILL_DEPTH = 8,
  parameter int LOOP_PERIOD = 4,
  parameter int THRESH_W    = 4,
  localparam int REQ_DEPTH  = K_OUT * (NODES - 1),
  localparam int RSP_DEPTH  = K_OUT,
  localparam int REQ_CW     = $clog2(REQ_DEPTH + 1),
  localparam int RSP_CW     = $clog2(RSP_DEPTH + 1),
  localparam int SP_CW      = $clog2(SPILL_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spill_mode_i,
  input  logic [THRESH_W-1:0] spill_thresh_i,
  input  logic                net_valid_i,
  input  logic                net_is_req_i,
  input  logic [DATA_W-1:0]   net_data_i,
  output logic                nack_o,
  output logic                req_valid_o,
  output logic [DATA_W-1:0]   req_data_o,
  input  logic                req_pop_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  input  logic                rsp_pop_i,
  output logic [REQ_CW-1:0]   req_count_o,
  output logic [RSP_CW-1:0]   rsp_count_o,
  output logic [SP_CW-1:0]    spill_count_o,
  output logic                spill_active_o
);
  logic [REQ_CW-1:0] req_cnt;
  logic [RSP_CW-1:0] rsp_cnt;
  logic [SP_CW-1:0]  sp_cnt;
  logic [DATA_W-1:0] sp_head, req_wdata;
  logic              req_push, rsp_push, relaunch;
  req_route_e        route;

  reqrep_spill_ctrl #(
    .THRESH_W   (THRESH_W),
    .LOOP_PERIOD(LOOP_PERIOD)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spill_mode_i (spill_mode_i),
    .thresh_i     (spill_thresh_i),
    .net_valid_i  (net_valid_i),
    .net_is_req_i (net_is_req_i),
    .req_full_i   (req_cnt == REQ_CW'(REQ_DEPTH)),
    .spill_empty_i(sp_cnt == '0),
    .spill_full_i (sp_cnt == SP_CW'(SPILL_DEPTH)),
    .spill_last_i (sp_cnt == SP_CW'(1)),
    .route_o      (route),
    .relaunch_o   (relaunch),
    .active_o     (spill_active_o)
  );

  // direct write and loopback never coincide: loopback needs a non-empty spill store
  assign req_push  = (route == RT_QUEUE) || relaunch;
  assign req_wdata = relaunch ? sp_head : net_data_i;
  assign rsp_push  = net_valid_i && !net_is_req_i;

  reqrep_fifo #(.W(DATA_W), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (req_push),
    .wdata_i(req_wdata),
    .pop_i  (req_pop_i),
    .rdata_o(req_data_o),
    .count_o(req_cnt)
  );

  reqrep_fifo #(.W(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rsp_push),
    .wdata_i(net_data_i),
    .pop_i  (rsp_pop_i),
    .rdata_o(rsp_data_o),
    .count_o(rsp_cnt)
  );

  reqrep_fifo #(.W(DATA_W), .DEPTH(SPILL_DEPTH)) u_spill_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (route == RT_SPILL),
    .wdata_i(net_data_i),
    .pop_i  (relaunch),
    .rdata_o(sp_head),
    .count_o(sp_cnt)
  );

  assign nack_o        = (route == RT_NACK);
  assign req_valid_o   = (req_cnt != '0);
  assign rsp_valid_o   = (rsp_cnt != '0);
  assign req_count_o   = req_cnt;
  assign rsp_count_o   = rsp_cnt;
  assign spill_count_o = sp_cnt;
endmodule

// File: rtl/reqrep_inq_chk.sv
module reqrep_inq_chk #(
  parameter int REQ_DEPTH   = 4,
  parameter int RSP_DEPTH   = 2,
  parameter int SPILL_DEPTH = 8,
  parameter int LOOP_PERIOD = 4,
  localparam int REQ_CW     = $clog2(REQ_DEPTH + 1),
  localparam int RSP_CW     = $clog2(RSP_DEPTH + 1),
  localparam int SP_CW      = $clog2(SPILL_DEPTH + 1),
  localparam int WW         = $clog2(LOOP_PERIOD + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spill_mode_i,
  input logic              net_valid_i,
  input logic              net_is_req_i,
  input logic              nack_i,
  input logic              relaunch_i,
  input logic [REQ_CW-1:0] req_count_i,
  input logic [RSP_CW-1:0] rsp_count_i,
  input logic [SP_CW-1:0]  spill_count_i,
  input logic              spill_active_i
);
  logic [WW-1:0] wait_q;
  logic          eligible;
  assign eligible = (spill_count_i != '0) && (req_count_i != REQ_CW'(REQ_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      wait_q <= '0;
    else if (eligible && !relaunch_i) wait_q <= wait_q + 1'b1;
    else                              wait_q <= '0;
  end

  // R1
  reply_no_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i |-> (net_valid_i && net_is_req_i));

  // R1
  reply_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_valid_i && !net_is_req_i) |-> (rsp_count_i < RSP_CW'(RSP_DEPTH)));

  // R3
  req_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_count_i <= REQ_CW'(REQ_DEPTH)) && (spill_count_i <= SP_CW'(SPILL_DEPTH)));

  // R5
  spill_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spill_active_i) |-> ($past(req_count_i) == REQ_CW'(REQ_DEPTH) && $past(spill_mode_i)));

  // R6
  spill_only_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_count_i != '0) |-> spill_active_i);

  // R7
  loopback_starve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q < WW'(LOOP_PERIOD));

  // R9
  spill_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spill_active_i) |-> (spill_count_i == '0));
endmodule

bind reqrep_inq reqrep_inq_chk #(
  .REQ_DEPTH  (REQ_DEPTH),
  .RSP_DEPTH  (RSP_DEPTH),
  .SPILL_DEPTH(SPILL_DEPTH),
  .LOOP_PERIOD(LOOP_PERIOD)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .spill_mode_i  (spill_mode_i),
  .net_valid_i   (net_valid_i),
  .net_is_req_i  (net_is_req_i),
  .nack_i        (nack_o),
  .relaunch_i    (relaunch),
  .req_count_i   (req_count_o),
  .rsp_count_i   (rsp_count_o),
  .spill_count_i (spill_count_o),
  .spill_active_i(spill_active_o)
);

// File: tb/reqrep_inq_test.sv
module reqrep_inq_test;
  localparam int DW = 8, K = 2, P = 3, SD = 8, LP = 4, TW = 4;
  localparam int RD = K * (P - 1), PD = K;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic spill_mode, net_valid, net_is_req, req_pop, rsp_pop;
  logic [TW-1:0] thr;
  logic [DW-1:0] net_data;
  logic nack, req_valid, rsp_valid, spill_active;
  logic [DW-1:0] req_data, rsp_data;
  logic [$clog2(RD+1)-1:0] req_count;
  logic [$clog2(PD+1)-1:0] rsp_count;
  logic [$clog2(SD+1)-1:0] spill_count;

  always #4 clk = ~clk;

  reqrep_inq #(.DATA_W(DW), .K_OUT(K), .NODES(P), .SPILL_DEPTH(SD),
               .LOOP_PERIOD(LP), .THRESH_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .spill_mode_i(spill_mode), .spill_thresh_i(thr),
    .net_valid_i(net_valid), .net_is_req_i(net_is_req), .net_data_i(net_data),
    .nack_o(nack), .req_valid_o(req_valid), .req_data_o(req_data), .req_pop_i(req_pop),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_pop_i(rsp_pop),
    .req_count_o(req_count), .rsp_count_o(rsp_count), .spill_count_o(spill_count),
    .spill_active_o(spill_active));

  int n_vec = 0, n_bad = 0;
  logic [DW-1:0] mq_req[$], mq_rsp[$], mq_sp[$];
  bit m_act = 0;
  int m_full = 0, m_starve = 0;
  int n_nack = 0, n_spill_seen = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(input bit v, input bit isreq, input logic [DW-1:0] d,
                      input bit rqp, input bit rpp, input bit mode, input int th);
    bit direct, tospill, exp_nack, elig, rel, rsp_in;
    bit rqp_e, rpp_e;
    logic [DW-1:0] rel_d;
    if (v && !isreq && mq_rsp.size() >= PD) v = 0;  // reply slots are reserved
    rqp_e = rqp && mq_req.size() > 0;
    rpp_e = rpp && mq_rsp.size() > 0;
    net_valid = v; net_is_req = isreq; net_data = d;
    req_pop = rqp_e; rsp_pop = rpp_e; spill_mode = mode; thr = TW'(th);
    #1;
    direct   = v && isreq && !m_act && mq_req.size() < RD;
    tospill  = v && isreq && m_act && mq_sp.size() < SD;
    exp_nack = v && isreq && !direct && !tospill;
    elig     = mq_sp.size() > 0 && mq_req.size() < RD;
    rel      = elig && (!v || m_starve == LP - 1);
    rsp_in   = v && !isreq;
    chk("R4 nack", int'(nack), int'(exp_nack));
    chk("R2 req_valid", int'(req_valid), int'(mq_req.size() > 0));
    if (mq_req.size() > 0) chk("R2 req_data order", int'(req_data), int'(mq_req[0]));
    chk("R1 rsp_valid", int'(rsp_valid), int'(mq_rsp.size() > 0));
    if (mq_rsp.size() > 0) chk("R1 rsp_data order", int'(rsp_data), int'(mq_rsp[0]));
    if (mq_sp.size() > 0) chk("R7 req_count during loopback", int'(req_count), mq_req.size());
    else                  chk("R8 req_count", int'(req_count), mq_req.size());
    chk("R8 rsp_count", int'(rsp_count), mq_rsp.size());
    chk("R6 spill_count", int'(spill_count), mq_sp.size());
    chk("R5 spill_active", int'(spill_active), int'(m_act));
    if (exp_nack) n_nack++;
    if (tospill) n_spill_seen++;
    // next model state
    if (rqp_e) void'(mq_req.pop_front());
    if (direct) mq_req.push_back(d);
    if (rel) begin rel_d = mq_sp.pop_front(); mq_req.push_back(rel_d); end
    if (tospill) mq_sp.push_back(d);
    if (rpp_e) void'(mq_rsp.pop_front());
    if (rsp_in) mq_rsp.push_back(d);
    begin
      bit watch;
      watch = !m_act && mode && (mq_req.size() - int'(rqp_e) + int'(direct) + int'(rel)) >= 0
              && (rqp_e ? mq_req.size() + 1 : mq_req.size()) >= 0;
      watch = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // model update of the control state must use the pre-edge occupancy, so it is kept apart
  int pre_req;
  bit pre_act;

  task automatic cyc(input bit v, input bit isreq, input logic [DW-1:0] d,
                     input bit rqp, input bit rpp, input bit mode, input int th);
    bit watch, sp_push, rel, elig, vv;
    int sp_sz;
    vv = v;
    if (vv && !isreq && mq_rsp.size() >= PD) vv = 0;
    pre_req = mq_req.size();
    sp_sz   = mq_sp.size();
    pre_act = m_act;
    sp_push = vv && isreq && m_act && sp_sz < SD;
    elig    = sp_sz > 0 && pre_req < RD;
    rel     = elig && (!vv || m_starve == LP - 1);
    watch   = !m_act && mode && pre_req == RD;
    step(vv, isreq, d, rqp, rpp, mode, th);
    if (pre_act) begin
      if ((rel && sp_sz == 1 && !sp_push) || (!mode && sp_sz == 0 && !sp_push)) m_act = 0;
    end else if (watch && m_full == th) m_act = 1;
    if (watch && m_full != th) m_full++; else m_full = 0;
    if (rel) m_starve = 0;
    else if (elig && vv) m_starve++;
    else m_starve = 0;
  endtask

  bit done = 0;

  initial begin
    net_valid = 0; net_is_req = 0; net_data = '0; req_pop = 0; rsp_pop = 0;
    spill_mode = 0; thr = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R10 reset state
    chk("R10 req_count", int'(req_count), 0);
    chk("R10 rsp_count", int'(rsp_count), 0);
    chk("R10 spill_count", int'(spill_count), 0);
    chk("R10 spill_active", int'(spill_active), 0);
    chk("R10 nack", int'(nack), 0);
    @(negedge clk);

    // R4 refuse mode: fill, overflow, reply while full (R1), R3 depth
    for (int i = 1; i <= RD; i++) cyc(1, 1, 8'(i), 0, 0, 0, 0);
    chk("R3 req depth", int'(req_count), RD);
    cyc(1, 1, 8'hAA, 0, 0, 0, 0);
    chk("R4 nack leaves queue", int'(req_count), RD);
    cyc(1, 0, 8'h51, 0, 0, 0, 0);
    cyc(1, 0, 8'h52, 0, 0, 0, 0);
    chk("R3 rsp depth", int'(rsp_count), PD);
    for (int i = 0; i < RD; i++) cyc(0, 0, 0, 1, 1, 0, 0);

    // R5 spill entry with threshold 2, then R6/R7 loopback under a busy port
    for (int i = 0; i < RD; i++) cyc(1, 1, 8'(16 + i), 0, 0, 1, 2);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 2);
    chk("R5 active after threshold", int'(spill_active), 1);
    for (int i = 0; i < 6; i++) cyc(1, 1, 8'(32 + i), 0, 0, 1, 2);
    for (int i = 0; i < 12; i++) cyc(1, i[0], 8'(48 + i), 1, 1, 1, 2);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 1, 1, 2);
    chk("R9 spill drained", int'(spill_count), 0);
    cyc(0, 0, 0, 0, 0, 0, 2);
    cyc(0, 0, 0, 0, 0, 0, 2);
    chk("R9 inactive", int'(spill_active), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, rq, mode;
      v    = ($urandom % 4) != 0;
      rq   = ($urandom % 10) < 7;
      mode = ((i / 500) % 4) != 3;
      cyc(v, rq, 8'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0, mode, int'((i / 250) % 5));
    end
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R4 nacks exercised", int'(n_nack > 0), 1);
    chk("R6 spills exercised", int'(n_spill_seen > 0), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule